// File: doc/BRIEF.md
# Serial-Load Segmented Converter Input Register

This block is the digital front end of a 12-bit voltage-output converter. A host shifts a code into it over a three-wire serial link: an active-low select, a serial clock and a data line. All three lines are sampled by a fast system clock through a synchroniser, and the block finds the edges itself. While select is low, each rising serial-clock edge shifts one data bit into a 12-bit shift register, most significant bit first. When select goes high, the shift register is copied into a holding register that drives the converter array.

The held code is offset binary, so code 2048 is the zero-volt output. The three top bits of the code are decoded into a seven-line thermometer pattern that selects the coarse segments. The nine low bits drive the binary section unchanged. Reset loads the midscale code, so the analog output starts at zero volts. A host that keeps select low through power-up can shift its first word in while the output stays at midscale.

Top module: `dac_front`

## Requirements
- R1: After reset the held code is midscale (binary 1000 0000 0000). So `seg_o` = 7'b0001111 and `lsb_o` = 0, and this remains true if select is low during and after reset until its first rise.
- R2: While `csel_ni` is low, each rising edge of `sclk_i` shifts `sdata_i` in, most significant bit first. A rise of `csel_ni` copies the last 12 bits into the held code. The outputs show the new code no later than the fourth system-clock edge after the rise.
- R3: When more than 12 bits are clocked in one low period of select, only the most recent 12 are held. Earlier bits are discarded.
- R4: The outputs change only after a select rise. Shifting a word with select low leaves them at the previous held code.
- R5: Rising serial-clock edges while select is high change neither the outputs nor the word latched at the next select rise.
- R6: For a held code with top bits n (code bits 11:9), `seg_o[i]` is 1 exactly for i < n. `lsb_o` equals code bits 8:0.
- R7: If a serial-clock rise and a select rise are sampled in the same system-clock cycle, that serial edge is not shifted. The held word is the 12 bits that came before it.
- R8: Timing is measured in system-clock cycles (default 4 ns). A valid update has at least 12 serial-clock rises while select is low. Serial-clock rises are at least 20 cycles apart, and select stays high for at least 10 cycles. An update that uses exactly these minimums latches correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csel_ni | input | 1 | Serial select, active low; a rising edge latches the word |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdata_i | input | 1 | Serial data, MSB first |
| seg_o | output | 7 | Thermometer segment selects from code bits 11:9 |
| lsb_o | output | 9 | Binary section, code bits 8:0 |

## Verification
The shift of a data bit and the latch into the holding register can fall in the same sampled cycle, because both come from edges that pass through the same synchroniser. The bench provokes this by raising select and a thirteenth serial-clock edge on the same system-clock cycle. It then expects the held code to be the earlier 12-bit word, not that word shifted by one more bit. A scoreboard queues every expected code when select rises and compares it once the synchroniser delay has passed. Direct checks confirm that the outputs hold still during shifting and during serial-clock activity while select is high.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  localparam int CODE_W          = 12;
  localparam int SEG_BITS        = 3;
  localparam int SYNC_STAGES     = 2;
  localparam int SCLK_MIN_CYC    = 20;  // 80 ns at 4 ns
  localparam int CS_HIGH_MIN_CYC = 10;  // 40 ns at 4 ns

  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t midscale();
    code_t c = '0;
    c[CODE_W-1] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/dac_front_sync.sv
module dac_front_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[0] <= RST_VAL;
        else         stg[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dac_front_shift.sv
module dac_front_shift #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         csel_ni,
  input  logic         sdata_i,
  output logic [W-1:0] word_o,
  output logic         load_o
);
  logic sclk_q, csel_q, shift_en;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      csel_q <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      csel_q <= csel_ni;
    end

  // select already high blocks a coincident serial edge
  assign shift_en = sclk_i & ~sclk_q & ~csel_ni;
  assign load_o   = csel_ni & ~csel_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       word_o <= '0;
    else if (shift_en) word_o <= {word_o[W-2:0], sdata_i};
endmodule

// File: rtl/dac_front_hold.sv
module dac_front_hold #(
  parameter int           W      = 12,
  parameter logic [W-1:0] PRESET = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     code_o <= PRESET;
    else if (load_i) code_o <= word_i;
endmodule

// File: rtl/dac_front_thermo.sv
module dac_front_thermo #(
  parameter int IN_W  = 3,
  parameter int OUT_W = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  bin_i,
  output logic [OUT_W-1:0] therm_o
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    assign therm_o[i] = (int'(bin_i) > i);
  end
endmodule

// File: rtl/dac_front.sv
module dac_front
  import dac_front_pkg::*;
#(
  parameter int CODE_W_P      = CODE_W,
  parameter int SEG_BITS_P    = SEG_BITS,
  parameter int SYNC_STAGES_P = SYNC_STAGES,
  localparam int SEG_W        = (1 << SEG_BITS_P) - 1,
  localparam int BIN_W        = CODE_W_P - SEG_BITS_P
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csel_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [BIN_W-1:0] lsb_o
);
  localparam logic [CODE_W_P-1:0] MID = {1'b1, {(CODE_W_P-1){1'b0}}};

  // order: {csel, sclk, sdata}; select idles high
  logic [2:0] sync_q;
  logic [CODE_W_P-1:0] word, code;
  logic load;

  dac_front_sync #(
    .STAGES (SYNC_STAGES_P),
    .W      (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({csel_ni, sclk_i, sdata_i}),
    .q_o    (sync_q)
  );

  dac_front_shift #(.W(CODE_W_P)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sync_q[1]),
    .csel_ni (sync_q[2]),
    .sdata_i (sync_q[0]),
    .word_o  (word),
    .load_o  (load)
  );

  dac_front_hold #(.W(CODE_W_P), .PRESET(MID)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i (word),
    .code_o (code)
  );

  dac_front_thermo #(.IN_W(SEG_BITS_P), .OUT_W(SEG_W)) u_thermo (
    .bin_i   (code[CODE_W_P-1 -: SEG_BITS_P]),
    .therm_o (seg_o)
  );

  assign lsb_o = code[BIN_W-1:0];
endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk #(
  parameter int CODE_W_P        = 12,
  parameter int SEG_BITS_P      = 3,
  parameter int SYNC_STAGES_P   = 2,
  parameter int SCLK_MIN_CYC    = 20,
  parameter int CS_HIGH_MIN_CYC = 10,
  localparam int SEG_W          = (1 << SEG_BITS_P) - 1,
  localparam int BIN_W          = CODE_W_P - SEG_BITS_P
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csel_ni,
  input logic             sclk_i,
  input logic [SEG_W-1:0] seg_o,
  input logic [BIN_W-1:0] lsb_o
);
  localparam int GAP_W = $clog2(SCLK_MIN_CYC + 1);
  localparam int BIT_W = $clog2(CODE_W_P + 1);
  localparam int HI_W  = $clog2(CS_HIGH_MIN_CYC + 1);
  localparam logic [SEG_W-1:0] MID_SEG = SEG_W'((1 << (1 << (SEG_BITS_P - 1))) - 1);

  logic sclk_p, cs_p, started;
  logic [GAP_W-1:0] gap;
  logic [BIT_W-1:0] bits;
  logic [HI_W-1:0]  hi;
  logic [SYNC_STAGES_P+1:0] cs_d;
  logic sclk_rise, cs_rise, cs_fall;

  assign sclk_rise = sclk_i & ~sclk_p;
  assign cs_rise   = csel_ni & ~cs_p;
  assign cs_fall   = ~csel_ni & cs_p;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_p  <= 1'b0;
      cs_p    <= 1'b1;
      started <= 1'b0;
      gap     <= GAP_W'(SCLK_MIN_CYC);
      bits    <= '0;
      hi      <= HI_W'(CS_HIGH_MIN_CYC);
      cs_d    <= '1;
    end else begin
      sclk_p  <= sclk_i;
      cs_p    <= csel_ni;
      started <= 1'b1;
      cs_d    <= {cs_d[SYNC_STAGES_P:0], csel_ni};
      if (sclk_rise) gap <= GAP_W'(1);
      else if (gap < GAP_W'(SCLK_MIN_CYC)) gap <= gap + 1'b1;
      if (cs_fall) bits <= '0;
      else if (sclk_rise && !csel_ni && bits < BIT_W'(CODE_W_P)) bits <= bits + 1'b1;
      if (cs_rise) hi <= HI_W'(1);
      else if (csel_ni && hi < HI_W'(CS_HIGH_MIN_CYC)) hi <= hi + 1'b1;
    end

  p_midscale_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |-> (seg_o == MID_SEG && lsb_o == '0));

  // R4, R5: outputs move only one synchroniser delay after a select rise
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({seg_o, lsb_o}) |-> (cs_d[SYNC_STAGES_P] && !cs_d[SYNC_STAGES_P+1]));

  p_thermo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o & (seg_o + SEG_W'(1))) == '0);

  p_frame_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |-> (bits >= BIT_W'(CODE_W_P)));

  p_sclk_period_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |-> (gap >= GAP_W'(SCLK_MIN_CYC)));

  p_cs_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |-> (hi >= HI_W'(CS_HIGH_MIN_CYC)));
endmodule

bind dac_front dac_front_chk #(
  .CODE_W_P        (CODE_W_P),
  .SEG_BITS_P      (SEG_BITS_P),
  .SYNC_STAGES_P   (SYNC_STAGES_P),
  .SCLK_MIN_CYC    (dac_front_pkg::SCLK_MIN_CYC),
  .CS_HIGH_MIN_CYC (dac_front_pkg::CS_HIGH_MIN_CYC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .csel_ni (csel_ni),
  .sclk_i  (sclk_i),
  .seg_o   (seg_o),
  .lsb_o   (lsb_o)
);

// File: tb/dac_front_test.sv
module dac_front_test;
  localparam int HALF = 10;   // serial half period in clk cycles
  localparam int HI   = 12;   // default select-high time

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sclk = 1'b0, din = 1'b0;
  logic [6:0] seg;
  logic [8:0] lsb;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [11:0] code; string tag; } item_t;
  item_t exp_q[$];
  event frame_ev;

  always #2 clk = ~clk;

  dac_front uut (
    .clk_i(clk), .rst_ni(rst_n), .csel_ni(cs_n),
    .sclk_i(sclk), .sdata_i(din), .seg_o(seg), .lsb_o(lsb)
  );

  function automatic logic [6:0] seg_of(logic [11:0] c);
    logic [6:0] r;
    for (int i = 0; i < 7; i++) r[i] = (int'(c[11:9]) > i);
    return r;
  endfunction

  task automatic compare(logic [11:0] c, string tag);
    n_cmp++;
    if (seg !== seg_of(c) || lsb !== c[8:0]) begin
      n_bad++;
      $display("FAIL %s: seg=%b lsb=%h expected seg=%b lsb=%h",
               tag, seg, lsb, seg_of(c), c[8:0]);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    din = b; sclk = 1'b0; wait_n(HALF);
    sclk = 1'b1; wait_n(HALF);
  endtask

  task automatic shift_word(logic [11:0] w);
    for (int i = 11; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic open_frame();
    cs_n = 1'b0; wait_n(10);
  endtask

  task automatic close_frame(logic [11:0] c, string tag, int hi);
    item_t it;
    it.code = c; it.tag = tag;
    cs_n = 1'b1;
    exp_q.push_back(it);
    -> frame_ev;
    wait_n(hi);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: compare once the sync + latch delay has passed
  initial forever begin
    item_t it;
    @(frame_ev);
    wait_n(8);
    it = exp_q.pop_front();
    compare(it.code, it.tag);
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    // R1: select low through reset
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);
    compare(12'h800, "R1 reset midscale");
    shift_word(12'h5A3);
    compare(12'h800, "R1/R4 midscale held while first word shifts");
    close_frame(12'h5A3, "R2 first word", HI);

    // R6: segment decode across top-bit values
    open_frame(); shift_word(12'h000); close_frame(12'h000, "R6 zero", HI);
    open_frame(); shift_word(12'hFFF); close_frame(12'hFFF, "R6 full", HI);
    open_frame(); shift_word(12'h200); close_frame(12'h200, "R6 n=1", HI);
    open_frame(); shift_word(12'hC55); close_frame(12'hC55, "R6 n=6", HI);
    open_frame(); shift_word(12'h9AB); close_frame(12'h9AB, "R2 word", HI);

    // R3: overlong frames
    open_frame(); shift_word(12'hF0F); shift_word(12'h3C6);
    close_frame(12'h3C6, "R3 24 bits", HI);
    open_frame(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); shift_word(12'h81E);
    close_frame(12'h81E, "R3 15 bits", HI);

    // R4: no change before select rises
    open_frame(); shift_word(12'h123);
    compare(12'h81E, "R4 held during shift");
    close_frame(12'h123, "R4 latched on rise", HI);

    // R5: serial activity with select high
    for (int i = 0; i < 6; i++) send_bit(i[0]);
    compare(12'h123, "R5 no change with select high");
    open_frame(); shift_word(12'h6E4); close_frame(12'h6E4, "R5 next word intact", HI);

    // R7: coincident serial edge and select rise
    open_frame(); shift_word(12'hABC);
    din = 1'b1; sclk = 1'b0; wait_n(HALF);
    sclk = 1'b1;
    close_frame(12'hABC, "R7 coincident edge not shifted", HI);

    // R8: minimum legal select-high time between updates
    open_frame(); shift_word(12'h7FF); close_frame(12'h7FF, "R8 min timing a", 10);
    open_frame(); shift_word(12'h801); close_frame(12'h801, "R8 min timing b", 10);

    wait_n(20);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d results left unchecked, expected 0", exp_q.size());
    end
    summary();
  end
endmodule